// File: doc/BRIEF.md
# DMA Request Arbiter with Bus-Ownership Outputs

This block takes six DMA request lines that arrive with no timing relation to the system clock. It brings each line into the clock domain and hands the bus to one requester at a time. The six lines serve channels 0, 1, 2, 3, 5 and 6. Channel 4 is reserved and has no line. Priority is fixed. When the block grants a line, it pulls that line's active-low acknowledge low. While the grant lasts, it also drives two bus-ownership indications. The first tells the rest of the system that the DMA side owns the address and command lines. The second holds the address-latch enable high instead of letting it pulse.

The block also reports whether the granted channel moves 8-bit or 16-bit data. A grant is never preempted. It ends only when an external cycle engine pulses a transfer-done input, and the released acknowledge stays high for at least one clock before the next grant. The block runs from a single 8 MHz system clock (125 ns period). Address and count registers, strobe generation and any processor interface belong to other blocks.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is active and on the first clock after it is released, every bit of `ack_n_o` is 1 and `bus_owned_o`, `ale_hold_o` and `xfer16_o` are 0.
- R2: Line index i of `req_i` and `ack_n_o` maps to channels as follows: indices 0 to 3 are channels 0 to 3, index 4 is channel 5 and index 5 is channel 6. A request that is held high from before rising edge k, with the block idle, pulls its acknowledge low right after edge k+2 (two synchronizer edges, then one grant edge). The acknowledge stays high after edge k+1.
- R3: When several synchronized requests are present at the grant edge, the lowest line index wins.
- R4: At most one bit of `ack_n_o` is 0 at any time.
- R5: `bus_owned_o` and `ale_hold_o` are 1 exactly while an acknowledge is low, and 0 otherwise.
- R6: `xfer16_o` is 1 while line 4 or line 5 is granted. It is 0 while line 0, 1, 2 or 3 is granted, and 0 while idle.
- R7: Once granted, the acknowledge does not change until `done_i` is sampled high. Requests that rise or fall meanwhile, including requests on higher-priority lines, have no effect on it.
- R8: A rising edge that samples `done_i` high during a grant releases all acknowledges right after that edge. No new grant appears before the following edge, which leaves at least one full clock with all acknowledges high.
- R9: `done_i` sampled high while no grant is active has no effect: all acknowledges stay high and the ownership outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 8 MHz |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 6 | Asynchronous active-high requests, index 0..5 = channels 0,1,2,3,5,6 |
| done_i | input | 1 | One-clock pulse from the cycle engine ending the current transfer |
| ack_n_o | output | 6 | Active-low acknowledges, same index mapping as `req_i` |
| bus_owned_o | output | 1 | High while the DMA side owns the address and command lines |
| ale_hold_o | output | 1 | Address-latch enable forced high during a grant |
| xfer16_o | output | 1 | High when the granted channel moves 16-bit data |

## Verification
The assertions assume that each requester keeps its line high until its acknowledge goes low and drops it after that. They also assume that `done_i` is pulsed only after the granted line has been low long enough to drain the synchronizer. If `done_i` arrives earlier, the stale synchronized request is granted again. That would be correct behaviour, but the per-pattern expectations do not model it. The stimulus changes inputs only on falling clock edges. After each grant, it drops every line and waits three clocks before pulsing `done_i`, so each pattern in the sweep of all 63 request combinations starts from an idle, drained state.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int unsigned LINES = 6;

    typedef struct packed {
        logic             busy;
        logic [LINES-1:0] gnt;
        logic             wide;
    } arb_state_t;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pick_o,
    output logic         any_o
);

    logic found;

    always_comb begin
        pick_o = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                pick_o[i] = 1'b1;
                found     = 1'b1;
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl
    import dma_arb_pkg::*;
#(
    parameter logic [LINES-1:0] WIDE_MASK = 6'b110000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_sync_i,
    input  logic [LINES-1:0] pick_i,
    input  logic             any_i,
    input  logic             done_i,
    output logic [LINES-1:0] gnt_o,
    output logic             busy_o,
    output logic             wide_o
);

    localparam logic [LINES-1:0] LSB_ONE = {{(LINES-1){1'b0}}, 1'b1};

    arb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (any_i) begin
                st_d.busy = 1'b1;
                st_d.gnt  = pick_i;
                st_d.wide = |(pick_i & WIDE_MASK);
            end
        end else if (done_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o  = st_q.gnt;
    assign busy_o = st_q.busy;
    assign wide_o = st_q.wide;

    // R4
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.gnt));

    // R3
    prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (((st_q.gnt - LSB_ONE) & $past(req_sync_i)) == '0));

    // R2
    grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> ((st_q.gnt & $past(req_sync_i)) != '0));

    // R7
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done_i) |=> ($stable(st_q.gnt) && st_q.busy));

    // R8
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && done_i) |=> (!st_q.busy && st_q.gnt == '0));

    // R9
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !any_i) |=> !st_q.busy);

    // R6
    width_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !st_q.wide);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [LINES-1:0] WIDE_MASK   = 6'b110000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_i,
    input  logic             done_i,
    output logic [LINES-1:0] ack_n_o,
    output logic             bus_owned_o,
    output logic             ale_hold_o,
    output logic             xfer16_o
);

    logic [LINES-1:0] req_sync;
    logic [LINES-1:0] pick;
    logic             any_req;
    logic [LINES-1:0] gnt;
    logic             busy;
    logic             wide;

    dma_req_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (req_i),
        .sync_o  (req_sync)
    );

    dma_prio_pick #(
        .N (LINES)
    ) u_pick (
        .req_i  (req_sync),
        .pick_o (pick),
        .any_o  (any_req)
    );

    dma_grant_ctrl #(
        .WIDE_MASK (WIDE_MASK)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_sync_i (req_sync),
        .pick_i     (pick),
        .any_i      (any_req),
        .done_i     (done_i),
        .gnt_o      (gnt),
        .busy_o     (busy),
        .wide_o     (wide)
    );

    assign ack_n_o     = ~gnt;
    assign bus_owned_o = busy;
    assign ale_hold_o  = busy;
    assign xfer16_o    = wide;

    // R5
    owner_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_owned_o && ale_hold_o) == (ack_n_o != '1));

    // R6
    wide_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_owned_o |-> (xfer16_o == ((~ack_n_o & WIDE_MASK) != '0)));

endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] req;
    logic       done;
    logic [5:0] ack_n;
    logic       owned;
    logic       ale;
    logic       x16;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_req_arbiter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .done_i      (done),
        .ack_n_o     (ack_n),
        .bus_owned_o (owned),
        .ale_hold_o  (ale),
        .xfer16_o    (x16)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(ack_n == 6'h3F, {tag, " ack"}, {26'd0, ack_n}, 32'h3F);
        chk(!owned && !ale, {tag, " owned/ale"}, {30'd0, owned, ale}, 32'h0);
        chk(!x16, {tag, " xfer16"}, {31'd0, x16}, 32'h0);
    endtask

    task automatic run_pattern(input logic [5:0] p);
        logic [5:0] exp_oh;
        bit         exp_wide;
        exp_oh   = p & (~p + 6'd1);
        exp_wide = (exp_oh[4] | exp_oh[5]);
        req = p;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(ack_n == 6'h3F, "R2 no grant before third edge", {26'd0, ack_n}, 32'h3F);
        @(posedge clk); @(negedge clk);
        chk(ack_n == ~exp_oh, "R3 R2 granted line", {26'd0, ack_n}, {26'd0, ~exp_oh});
        chk($countones(~ack_n) == 1, "R4 single ack", {26'd0, ack_n}, {26'd0, ~exp_oh});
        chk(owned && ale, "R5 ownership during grant", {30'd0, owned, ale}, 32'h3);
        chk(x16 == exp_wide, "R6 width flag", {31'd0, x16}, {31'd0, exp_wide});
        req = 6'h3F;
        repeat (3) @(negedge clk);
        chk(ack_n == ~exp_oh, "R7 no preemption", {26'd0, ack_n}, {26'd0, ~exp_oh});
        req = 6'h00;
        repeat (3) @(negedge clk);
        chk(ack_n == ~exp_oh, "R7 held after request drop", {26'd0, ack_n}, {26'd0, ~exp_oh});
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk_idle("R8 release after done");
        @(negedge clk);
        chk_idle("R8 stays idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req   = '0;
        done  = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");

        // R9: stray done while idle
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk_idle("R9 idle done ignored");
        @(negedge clk);
        chk_idle("R9 idle done ignored later");

        // R2 R3 R6 R7 R8: every request combination
        for (int p = 1; p < 64; p++) begin
            run_pattern(p[5:0]);
        end

        // R8: back-to-back grants with gap
        req = 6'b010001;
        repeat (3) @(negedge clk);
        chk(ack_n == 6'b111110, "R3 line0 over line4", {26'd0, ack_n}, 32'h3E);
        req = 6'b010000;
        repeat (3) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk(ack_n == 6'h3F, "R8 gap clock", {26'd0, ack_n}, 32'h3F);
        @(negedge clk);
        chk(ack_n == 6'b101111, "R8 next grant after gap", {26'd0, ack_n}, 32'h2F);
        chk(x16, "R6 line4 is 16-bit", {31'd0, x16}, 32'h1);
        req = 6'h00;
        repeat (3) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);
        chk_idle("R8 final idle");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule